// File: doc/BRIEF.md
# Short forward branch predication fuser

This block sits between instruction fetch and issue in a simple in-order pipeline that executes 32-bit and 16-bit (compressed) RISC-V encodings. Each cycle it looks at the first two instructions offered by fetch. Suppose the first is a conditional branch whose forward target is exactly the address just past the next instruction. Then the pair is collapsed into a single operation: the shadowed instruction, tagged with a predicate that tells the back end to execute it only when the branch condition is false. No redirect of control flow takes place in that case. Any other instruction, or any branch that does not meet these rules, goes through on its own and unchanged.

Fetch offers two slots. Each slot has a valid flag, a 32-bit instruction word (a compressed instruction sits in the low half), its PC, and a flag that marks it as a 4-byte encoding. The block returns one acknowledge per slot for the slots it consumed in that cycle. The second slot is never consumed without the first. The result leaves through a single registered output stage with valid/ready handshaking. Along with it come a byte length by which the PC must advance and a predicate bundle: an inverted compare code and two register specifiers. The block does not evaluate the condition or execute the operation.

Top module: `sfb_fuser`

## Requirements
- R1: After reset, out_valid is 0. With no valid input, in0_ack and in1_ack stay 0.
- R2: Fusion needs all of the following. The first instruction is a conditional branch. Its offset is positive and equals the branch length plus the next instruction's length. The next instruction's PC equals the branch PC plus the branch length. The shadowed instruction is allowed. When fused, both slots are acknowledged together. The next cycle then shows out_fused=1, out_instr equal to the shadowed word, out_pc equal to the branch PC, and out_len equal to the sum of both lengths in bytes.
- R3: A compressed branch (BEQZ/BNEZ, quadrant 01, funct3 110/111, compare register x(8+bits[9:7])) fuses on the same terms. The 2+4, 4+2 and 2+2 byte combinations give out_len 6, 6 and 4.
- R4: A non-branch, or a branch with a zero, backward or other-distance offset, leaves alone. Only in0 is acknowledged, with out_fused=0, out_len 4 or 2 (following the wide flag), and out_pc and out_instr taken from that instruction.
- R5: The predicate carries the branch compare inverted. For 32-bit branches pred_cmp is funct3 XOR 001 and pred_rs1/pred_rs2 are the branch register fields. BEQZ gives pred_cmp 001 and BNEZ gives 000, with pred_rs2 = 0. For unfused output all three predicate fields are 0.
- R6: Fusion is refused when the shadowed instruction is a branch, jump, system or load/store. Refused 32-bit opcodes: 1100011, 1101111, 1100111, 1110011, 0000011, 0100011. Refused compressed forms: quadrant 00 with funct3≠000, quadrant 01 with funct3 001/101/110/111, quadrant 10 with funct3 001/010/011/101/110/111, and quadrant 10 funct3 100 with bits[6:2]=0 and either bits[11:7]≠0 or bit 12 set. In that case the branch leaves alone and the second slot is not acknowledged.
- R7: Suppose in1 is invalid and in0 is a branch whose offset could fit a 2- or 4-byte successor. The branch is then acknowledged and held, with no output in the following cycle. In the next cycle the held branch pairs with the new in0, which gets in0_ack if they fuse. If they do not fuse, or no instruction arrives, the held branch is released unfused.
- R8: While flush is 1, nothing is acknowledged, a held branch is discarded, and out_valid is 0 in the next cycle.
- R9: While out_valid=1 and out_ready=0 (no flush), nothing is acknowledged and every output stays unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush | input | 1 | Discards held and pending work |
| in0_valid | input | 1 | First slot valid |
| in0_instr | input | 32 | First slot instruction word |
| in0_pc | input | 32 | First slot PC |
| in0_wide | input | 1 | First slot is a 4-byte encoding |
| in0_ack | output | 1 | First slot consumed this cycle |
| in1_valid | input | 1 | Second slot valid |
| in1_instr | input | 32 | Second slot instruction word |
| in1_pc | input | 32 | Second slot PC |
| in1_wide | input | 1 | Second slot is a 4-byte encoding |
| in1_ack | output | 1 | Second slot consumed this cycle |
| out_valid | output | 1 | Output operation valid |
| out_ready | input | 1 | Issue accepts the output |
| out_instr | output | 32 | Instruction word to issue |
| out_pc | output | 32 | PC of the operation |
| out_len | output | 4 | Bytes the PC advances |
| out_fused | output | 1 | Operation is predicated |
| pred_cmp | output | 3 | Inverted compare code |
| pred_rs1 | output | 5 | First compare register |
| pred_rs2 | output | 5 | Second compare register |

## Verification
Two events can fall in the same cycle. A branch held while waiting for its partner may be due for release or pairing in the very cycle that flush is raised. Likewise, a flush may arrive while the output is stalled by out_ready low. The bench provokes both directly: first it parks a branch with the second slot empty, then raises flush alongside a valid fusable successor. It also raises flush with a pending stalled output. The behavioural model expects no acknowledge in either case and an empty output afterwards. Every cycle compares acknowledges and all output fields against that model.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
    parameter int unsigned SFB_PC_W  = 32;
    parameter int unsigned SFB_ILEN  = 32;
    parameter int unsigned SFB_LEN_W = 4;
    localparam int unsigned SFB_OFF_W = 13;
    localparam int unsigned SFB_REG_W = 5;
    localparam int unsigned SFB_CMP_W = 3;

    typedef struct packed {
        logic                v;
        logic [SFB_ILEN-1:0] instr;
        logic [SFB_PC_W-1:0] pc;
        logic                wide;
    } slot_t;

    typedef struct packed {
        logic                 v;
        logic [SFB_ILEN-1:0]  instr;
        logic [SFB_PC_W-1:0]  pc;
        logic [SFB_LEN_W-1:0] len;
        logic                 fused;
        logic [SFB_CMP_W-1:0] cmp;
        logic [SFB_REG_W-1:0] rs1;
        logic [SFB_REG_W-1:0] rs2;
    } op_t;

    typedef struct packed {
        slot_t hold;
        op_t   out;
    } state_t;

    function automatic logic [SFB_LEN_W-1:0] slot_len(input logic wide);
        return wide ? SFB_LEN_W'(4) : SFB_LEN_W'(2);
    endfunction
endpackage

// File: rtl/sfb_pair_sel.sv
module sfb_pair_sel
    import sfb_pkg::*;
(
    input  slot_t held,
    input  slot_t s0,
    input  slot_t s1,
    output slot_t lead,
    output slot_t follow,
    output logic  lead_held
);
    always_comb begin
        lead_held = held.v;
        if (held.v) begin
            lead   = held;
            follow = s0;
        end else begin
            lead   = s0;
            follow = s1;
        end
    end
endmodule

// File: rtl/sfb_br_dec.sv
module sfb_br_dec
    import sfb_pkg::*;
#(
    parameter bit ALLOW_C = 1'b1
) (
    input  logic [SFB_ILEN-1:0]  instr,
    input  logic                 wide,
    output logic                 is_br,
    output logic [SFB_OFF_W-1:0] off,
    output logic [SFB_CMP_W-1:0] cmp_inv,
    output logic [SFB_REG_W-1:0] rs1,
    output logic [SFB_REG_W-1:0] rs2
);
    logic                 w_br;
    logic [SFB_OFF_W-1:0] w_off;
    logic                 c_br;
    logic [SFB_OFF_W-1:0] c_off;
    logic [SFB_CMP_W-1:0] c_cmp;
    logic [SFB_REG_W-1:0] c_rs1;

    // 32-bit conditional branch: opcode 1100011, funct3 010/011 reserved
    always_comb begin
        w_br  = (instr[6:0] == 7'b1100011) && (instr[14:13] != 2'b01);
        w_off = {instr[31], instr[7], instr[30:25], instr[11:8], 1'b0};
    end

    generate
        if (ALLOW_C) begin : g_cbr
            logic [8:0] raw;
            always_comb begin
                raw   = {instr[12], instr[6:5], instr[2], instr[11:10], instr[4:3], 1'b0};
                c_br  = (instr[1:0] == 2'b01) && (instr[15:14] == 2'b11);
                c_off = {{(SFB_OFF_W-9){raw[8]}}, raw};
                c_cmp = instr[13] ? 3'b000 : 3'b001;
                c_rs1 = {2'b01, instr[9:7]};
            end
        end else begin : g_nocbr
            always_comb begin
                c_br  = 1'b0;
                c_off = '0;
                c_cmp = '0;
                c_rs1 = '0;
            end
        end
    endgenerate

    always_comb begin
        if (wide) begin
            is_br   = w_br;
            off     = w_off;
            cmp_inv = instr[14:12] ^ 3'b001;
            rs1     = instr[19:15];
            rs2     = instr[24:20];
        end else begin
            is_br   = c_br;
            off     = c_off;
            cmp_inv = c_cmp;
            rs1     = c_rs1;
            rs2     = '0;
        end
    end
endmodule

// File: rtl/sfb_shadow_ok.sv
module sfb_shadow_ok
    import sfb_pkg::*;
(
    input  logic [SFB_ILEN-1:0] instr,
    input  logic                wide,
    output logic                ok
);
    logic wide_bad;
    logic narrow_bad;

    always_comb begin
        case (instr[6:0])
            7'b1100011, 7'b1101111, 7'b1100111,
            7'b1110011, 7'b0000011, 7'b0100011: wide_bad = 1'b1;
            default:                            wide_bad = 1'b0;
        endcase
    end

    always_comb begin
        narrow_bad = 1'b0;
        unique case (instr[1:0])
            2'b00: narrow_bad = (instr[15:13] != 3'b000);
            2'b01: begin
                case (instr[15:13])
                    3'b001, 3'b101, 3'b110, 3'b111: narrow_bad = 1'b1;
                    default:                        narrow_bad = 1'b0;
                endcase
            end
            2'b10: begin
                case (instr[15:13])
                    3'b000:  narrow_bad = 1'b0;
                    3'b100:  narrow_bad = (instr[6:2] == 5'd0) &&
                                          ((instr[11:7] != 5'd0) || instr[12]);
                    default: narrow_bad = 1'b1;
                endcase
            end
            default: narrow_bad = 1'b0;
        endcase
    end

    assign ok = wide ? !wide_bad : !narrow_bad;
endmodule

// File: rtl/sfb_fuser.sv
module sfb_fuser
    import sfb_pkg::*;
#(
    parameter bit ALLOW_C = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush,
    input  logic                  in0_valid,
    input  logic [SFB_ILEN-1:0]   in0_instr,
    input  logic [SFB_PC_W-1:0]   in0_pc,
    input  logic                  in0_wide,
    output logic                  in0_ack,
    input  logic                  in1_valid,
    input  logic [SFB_ILEN-1:0]   in1_instr,
    input  logic [SFB_PC_W-1:0]   in1_pc,
    input  logic                  in1_wide,
    output logic                  in1_ack,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [SFB_ILEN-1:0]   out_instr,
    output logic [SFB_PC_W-1:0]   out_pc,
    output logic [SFB_LEN_W-1:0]  out_len,
    output logic                  out_fused,
    output logic [SFB_CMP_W-1:0]  pred_cmp,
    output logic [SFB_REG_W-1:0]  pred_rs1,
    output logic [SFB_REG_W-1:0]  pred_rs2
);
    state_t st_q, st_d;
    slot_t  s0, s1, lead, follow;
    logic   lead_held;

    logic                 br;
    logic [SFB_OFF_W-1:0] off;
    logic [SFB_CMP_W-1:0] cmp_inv;
    logic [SFB_REG_W-1:0] br_rs1, br_rs2;
    logic                 shadow_ok;

    logic [SFB_LEN_W-1:0] len_a, len_b, len_sum;
    logic                 forward, adjacent, pair_fits, may_wait, can_load;
    op_t                  op_single, op_fused;

    assign s0 = '{v: in0_valid, instr: in0_instr, pc: in0_pc, wide: in0_wide};
    assign s1 = '{v: in1_valid, instr: in1_instr, pc: in1_pc, wide: in1_wide};

    sfb_pair_sel u_sel (
        .held     (st_q.hold),
        .s0       (s0),
        .s1       (s1),
        .lead     (lead),
        .follow   (follow),
        .lead_held(lead_held)
    );

    sfb_br_dec #(.ALLOW_C(ALLOW_C)) u_dec (
        .instr  (lead.instr),
        .wide   (lead.wide),
        .is_br  (br),
        .off    (off),
        .cmp_inv(cmp_inv),
        .rs1    (br_rs1),
        .rs2    (br_rs2)
    );

    sfb_shadow_ok u_shadow (
        .instr(follow.instr),
        .wide (follow.wide),
        .ok   (shadow_ok)
    );

    always_comb begin
        len_a     = slot_len(lead.wide);
        len_b     = slot_len(follow.wide);
        len_sum   = len_a + len_b;
        forward   = lead.v && br && !off[SFB_OFF_W-1];
        adjacent  = follow.pc == (lead.pc + SFB_PC_W'(len_a));
        pair_fits = forward && follow.v && shadow_ok && adjacent &&
                    (off == SFB_OFF_W'(len_sum));
        may_wait  = forward && !follow.v && !lead_held &&
                    ((off == SFB_OFF_W'(len_a + SFB_LEN_W'(2))) ||
                     (off == SFB_OFF_W'(len_a + SFB_LEN_W'(4))));
        can_load  = !st_q.out.v || out_ready;

        op_single       = '0;
        op_single.v     = 1'b1;
        op_single.instr = lead.instr;
        op_single.pc    = lead.pc;
        op_single.len   = len_a;

        op_fused        = '0;
        op_fused.v      = 1'b1;
        op_fused.instr  = follow.instr;
        op_fused.pc     = lead.pc;
        op_fused.len    = len_sum;
        op_fused.fused  = 1'b1;
        op_fused.cmp    = cmp_inv;
        op_fused.rs1    = br_rs1;
        op_fused.rs2    = br_rs2;
    end

    always_comb begin
        st_d    = st_q;
        in0_ack = 1'b0;
        in1_ack = 1'b0;
        if (flush) begin
            st_d.hold = '0;
            st_d.out  = '0;
        end else if (can_load) begin
            st_d.out = '0;
            if (lead.v) begin
                if (lead_held) begin
                    st_d.hold = '0;
                    if (pair_fits) begin
                        st_d.out = op_fused;
                        in0_ack  = 1'b1;
                    end else begin
                        st_d.out = op_single;
                    end
                end else if (pair_fits) begin
                    st_d.out = op_fused;
                    in0_ack  = 1'b1;
                    in1_ack  = 1'b1;
                end else if (may_wait) begin
                    st_d.hold = lead;
                    in0_ack   = 1'b1;
                end else begin
                    st_d.out = op_single;
                    in0_ack  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.out.v;
    assign out_instr = st_q.out.instr;
    assign out_pc    = st_q.out.pc;
    assign out_len   = st_q.out.len;
    assign out_fused = st_q.out.fused;
    assign pred_cmp  = st_q.out.cmp;
    assign pred_rs1  = st_q.out.rs1;
    assign pred_rs2  = st_q.out.rs2;
endmodule

// File: rtl/sfb_fuser_chk.sv
module sfb_fuser_chk
    import sfb_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 flush,
    input logic                 in0_valid,
    input logic                 in0_ack,
    input logic                 in1_ack,
    input logic                 out_valid,
    input logic                 out_ready,
    input logic [SFB_ILEN-1:0]  out_instr,
    input logic [SFB_PC_W-1:0]  out_pc,
    input logic [SFB_LEN_W-1:0] out_len,
    input logic                 out_fused,
    input logic [SFB_CMP_W-1:0] pred_cmp,
    input logic [SFB_REG_W-1:0] pred_rs1,
    input logic [SFB_REG_W-1:0] pred_rs2
);
    assert_ack_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in1_ack |-> in0_ack);

    assert_ack_needs_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in0_ack |-> in0_valid);

    assert_fused_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_fused) |-> (out_len == 4 || out_len == 6 || out_len == 8));

    assert_single_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_fused) |-> (out_len == 2 || out_len == 4));

    assert_pred_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !out_fused |-> (pred_cmp == 0 && pred_rs1 == 0 && pred_rs2 == 0));

    assert_flush_noack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (!in0_ack && !in1_ack));

    assert_flush_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !out_valid);

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !flush) |=>
            (out_valid && $stable(out_instr) && $stable(out_pc) && $stable(out_len)
             && $stable(out_fused) && $stable(pred_cmp)));

    assert_stall_noack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in0_ack);
endmodule

bind sfb_fuser sfb_fuser_chk u_chk (.*);

// File: tb/tb_sfb_fuser.sv
module tb_sfb_fuser;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        in0_valid = 1'b0, in1_valid = 1'b0;
    logic [31:0] in0_instr = '0, in1_instr = '0, in0_pc = '0, in1_pc = '0;
    logic        in0_wide = 1'b0, in1_wide = 1'b0;
    logic        in0_ack, in1_ack;
    logic        out_valid, out_fused;
    logic        out_ready = 1'b1;
    logic [31:0] out_instr, out_pc;
    logic [3:0]  out_len;
    logic [2:0]  pred_cmp;
    logic [4:0]  pred_rs1, pred_rs2;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sfb_fuser dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .in0_valid(in0_valid), .in0_instr(in0_instr), .in0_pc(in0_pc), .in0_wide(in0_wide), .in0_ack(in0_ack),
        .in1_valid(in1_valid), .in1_instr(in1_instr), .in1_pc(in1_pc), .in1_wide(in1_wide), .in1_ack(in1_ack),
        .out_valid(out_valid), .out_ready(out_ready), .out_instr(out_instr), .out_pc(out_pc),
        .out_len(out_len), .out_fused(out_fused), .pred_cmp(pred_cmp),
        .pred_rs1(pred_rs1), .pred_rs2(pred_rs2)
    );

    localparam logic [31:0] ADDI  = 32'h00108113;
    localparam logic [31:0] LW    = 32'h0000a103;
    localparam logic [31:0] JAL   = 32'h0080006f;
    localparam logic [31:0] ECALL = 32'h00000073;
    localparam logic [31:0] CADDI = 32'h00000085;
    localparam logic [31:0] CLW   = 32'h00004188;
    localparam logic [31:0] CJ    = 32'h0000a001;

    // behavioural reference state
    bit          mh_v, mh_w;
    logic [31:0] mh_i, mh_pc;
    bit          mo_v, mo_f;
    logic [31:0] mo_i, mo_pc;
    int          mo_len;
    logic [2:0]  mo_c;
    logic [4:0]  mo_r1, mo_r2;

    function automatic logic [31:0] eb(logic [2:0] f3, logic [4:0] r1, logic [4:0] r2, int off);
        logic [12:0] o = off[12:0];
        return {o[12], o[10:5], r2, r1, f3, o[4:1], o[11], 7'h63};
    endfunction

    function automatic logic [31:0] ecb(bit nez, logic [2:0] rp, int off);
        logic [8:0] o = off[8:0];
        return {16'h0, 2'b11, nez, o[8], o[4:3], rp, o[7:6], o[2:1], o[5], 2'b01};
    endfunction

    task automatic dec(input logic [31:0] x, input bit w, output bit isb, output int off,
                       output logic [2:0] c, output logic [4:0] r1, output logic [4:0] r2);
        logic signed [12:0] t;
        logic signed [8:0]  u;
        isb = 0; off = 0; c = 0; r1 = 0; r2 = 0;
        if (w) begin
            if (x[6:0] == 7'h63 && x[14:12] != 3'd2 && x[14:12] != 3'd3) begin
                isb = 1;
                t = {x[31], x[7], x[30:25], x[11:8], 1'b0};
                off = int'(t);
                c = x[14:12] ^ 3'd1;
                r1 = x[19:15];
                r2 = x[24:20];
            end
        end else if (x[1:0] == 2'b01 && x[15:14] == 2'b11) begin
            isb = 1;
            u = {x[12], x[6:5], x[2], x[11:10], x[4:3], 1'b0};
            off = int'(u);
            c = x[13] ? 3'd0 : 3'd1;
            r1 = 5'd8 + 5'(x[9:7]);
        end
    endtask

    function automatic bit refused(logic [31:0] x, bit w);
        int f = int'(x[15:13]);
        if (w) return x[6:0] inside {7'h63, 7'h6f, 7'h67, 7'h73, 7'h03, 7'h23};
        if (x[1:0] == 2'b00) return f != 0;
        if (x[1:0] == 2'b01) return f inside {1, 5, 6, 7};
        if (x[1:0] == 2'b10) begin
            if (f == 4) return (x[6:2] == 0) && (x[11:7] != 0 || x[12]);
            return f != 0;
        end
        return 0;
    endfunction

    task automatic chk(string tag, string what, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic cyc(string tag, bit v0, logic [31:0] i0, logic [31:0] p0, bit w0,
                       bit v1, logic [31:0] i1, logic [31:0] p1, bit w1, bit ordy, bit fl);
        bit av, bv, ah, aw, bw, isb, fits, waits, canl, e0, e1;
        logic [31:0] ai, ap, bi, bp;
        logic [2:0] c;
        logic [4:0] r1, r2;
        int off, la, lb;
        in0_valid = v0; in0_instr = i0; in0_pc = p0; in0_wide = w0;
        in1_valid = v1; in1_instr = i1; in1_pc = p1; in1_wide = w1;
        out_ready = ordy; flush = fl;
        ah = mh_v;
        if (mh_v) begin
            av = 1; ai = mh_i; ap = mh_pc; aw = mh_w;
            bv = v0; bi = i0; bp = p0; bw = w0;
        end else begin
            av = v0; ai = i0; ap = p0; aw = w0;
            bv = v1; bi = i1; bp = p1; bw = w1;
        end
        dec(ai, aw, isb, off, c, r1, r2);
        la = aw ? 4 : 2;
        lb = bw ? 4 : 2;
        fits  = av && isb && off > 0 && off == la + lb && bv && !refused(bi, bw) && bp == ap + la;
        waits = av && isb && off > 0 && !ah && !bv && (off == la + 2 || off == la + 4);
        canl  = !mo_v || ordy;
        e0 = 0; e1 = 0;
        #1;
        if (fl) begin
            mh_v = 0; mo_v = 0;
        end else if (canl) begin
            mo_v = 0;
            if (av) begin
                if (fits) begin
                    mo_v = 1; mo_f = 1; mo_i = bi; mo_pc = ap; mo_len = la + lb;
                    mo_c = c; mo_r1 = r1; mo_r2 = r2;
                    e0 = 1; e1 = !ah; mh_v = 0;
                end else if (waits) begin
                    mh_v = 1; mh_i = ai; mh_pc = ap; mh_w = aw; e0 = 1;
                end else begin
                    mo_v = 1; mo_f = 0; mo_i = ai; mo_pc = ap; mo_len = la;
                    mo_c = 0; mo_r1 = 0; mo_r2 = 0;
                    e0 = !ah; mh_v = 0;
                end
            end
        end
        chk(tag, "in0_ack", in0_ack, e0);
        chk(tag, "in1_ack", in1_ack, e1);
        @(posedge clk);
        @(negedge clk);
        chk(tag, "out_valid", out_valid, mo_v);
        if (mo_v) begin
            chk(tag, "out_instr", out_instr, mo_i);
            chk(tag, "out_pc", out_pc, mo_pc);
            chk(tag, "out_len", out_len, mo_len);
            chk(tag, "out_fused", out_fused, mo_f);
            chk(tag, "pred_cmp", pred_cmp, mo_c);
            chk(tag, "pred_rs1", pred_rs1, mo_r1);
            chk(tag, "pred_rs2", pred_rs2, mo_r2);
        end
    endtask

    task automatic idle(string tag);
        cyc(tag, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    endtask

    task automatic pair(string tag, logic [31:0] a, logic [31:0] pa, bit wa,
                        logic [31:0] b, logic [31:0] pb, bit wb);
        cyc(tag, 1, a, pa, wa, 1, b, pb, wb, 1, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        mh_v = 0; mo_v = 0;
        repeat (3) @(negedge clk);
        chk("R1", "out_valid in reset", out_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "out_valid after reset", out_valid, 0);
        chk("R1", "in0_ack idle", in0_ack, 0);
        chk("R1", "in1_ack idle", in1_ack, 0);

        // R2: 32-bit branch over 32-bit instruction
        pair("R2", eb(3'b000, 5'd1, 5'd2, 8), 32'h100, 1, ADDI, 32'h104, 1);
        idle("R2");
        // R2: non-adjacent successor PC blocks fusion
        pair("R2", eb(3'b000, 5'd1, 5'd2, 8), 32'h120, 1, ADDI, 32'h128, 1);
        idle("R2");

        // R3: compressed combinations
        pair("R3", ecb(1, 3'd0, 6), 32'h200, 0, ADDI, 32'h202, 1);
        pair("R3", eb(3'b001, 5'd3, 5'd4, 6), 32'h300, 1, CADDI, 32'h304, 0);
        pair("R3", ecb(0, 3'd5, 4), 32'h400, 0, CADDI, 32'h402, 0);
        idle("R3");

        // R4: wrong distance, backward, zero offset, non-branch
        pair("R4", eb(3'b000, 5'd1, 5'd2, 12), 32'h500, 1, ADDI, 32'h504, 1);
        pair("R4", eb(3'b000, 5'd1, 5'd2, -4), 32'h510, 1, ADDI, 32'h514, 1);
        pair("R4", eb(3'b000, 5'd1, 5'd2, 0), 32'h520, 1, ADDI, 32'h524, 1);
        pair("R4", ADDI, 32'h530, 1, ADDI, 32'h534, 1);
        pair("R4", CADDI, 32'h540, 0, ADDI, 32'h542, 1);
        idle("R4");

        // R5: predicate inversion
        pair("R5", eb(3'b100, 5'd7, 5'd9, 8), 32'h600, 1, ADDI, 32'h604, 1);
        pair("R5", eb(3'b111, 5'd10, 5'd11, 8), 32'h610, 1, ADDI, 32'h614, 1);
        pair("R5", eb(3'b001, 5'd12, 5'd13, 8), 32'h620, 1, ADDI, 32'h624, 1);
        pair("R5", ecb(1, 3'd2, 4), 32'h630, 0, CADDI, 32'h632, 0);
        pair("R5", ecb(0, 3'd7, 4), 32'h640, 0, CADDI, 32'h642, 0);
        idle("R5");

        // R6: refused shadow instructions
        pair("R6", eb(3'b000, 5'd1, 5'd2, 8), 32'h700, 1, LW, 32'h704, 1);
        pair("R6", eb(3'b000, 5'd1, 5'd2, 8), 32'h710, 1, JAL, 32'h714, 1);
        pair("R6", eb(3'b000, 5'd1, 5'd2, 8), 32'h720, 1, ECALL, 32'h724, 1);
        pair("R6", eb(3'b000, 5'd1, 5'd2, 8), 32'h730, 1, eb(3'b000, 5'd1, 5'd2, 8), 32'h734, 1);
        pair("R6", ecb(0, 3'd1, 4), 32'h740, 0, CLW, 32'h742, 0);
        pair("R6", ecb(0, 3'd1, 4), 32'h750, 0, CJ, 32'h752, 0);
        idle("R6");

        // R7: hold then pair, hold then release, hold then refused
        cyc("R7", 1, eb(3'b000, 5'd1, 5'd2, 8), 32'h800, 1, 0, 0, 0, 0, 1, 0);
        cyc("R7", 1, ADDI, 32'h804, 1, 0, 0, 0, 0, 1, 0);
        idle("R7");
        cyc("R7", 1, eb(3'b101, 5'd1, 5'd2, 6), 32'h810, 1, 0, 0, 0, 0, 1, 0);
        idle("R7");
        idle("R7");
        cyc("R7", 1, eb(3'b000, 5'd1, 5'd2, 8), 32'h820, 1, 0, 0, 0, 0, 1, 0);
        cyc("R7", 1, LW, 32'h824, 1, 0, 0, 0, 0, 1, 0);
        cyc("R7", 1, LW, 32'h824, 1, 0, 0, 0, 0, 1, 0);
        idle("R7");

        // R8: flush with fusable pair, flush during hold, flush during stall
        cyc("R8", 1, eb(3'b000, 5'd1, 5'd2, 8), 32'h900, 1, 1, ADDI, 32'h904, 1, 1, 1);
        cyc("R8", 1, eb(3'b000, 5'd1, 5'd2, 8), 32'h910, 1, 0, 0, 0, 0, 1, 0);
        cyc("R8", 1, ADDI, 32'h914, 1, 0, 0, 0, 0, 1, 1);
        idle("R8");
        cyc("R8", 1, ADDI, 32'h920, 1, 0, 0, 0, 0, 0, 0);
        cyc("R8", 1, ADDI, 32'h924, 1, 0, 0, 0, 0, 0, 1);
        idle("R8");

        // R9: backpressure
        cyc("R9", 1, eb(3'b000, 5'd1, 5'd2, 8), 32'hA00, 1, 1, ADDI, 32'hA04, 1, 0, 0);
        cyc("R9", 1, ADDI, 32'hA08, 1, 1, ADDI, 32'hA0C, 1, 0, 0);
        cyc("R9", 1, ADDI, 32'hA08, 1, 1, ADDI, 32'hA0C, 1, 0, 0);
        cyc("R9", 1, ADDI, 32'hA08, 1, 1, ADDI, 32'hA0C, 1, 1, 0);
        idle("R9");

        // mixed stream
        for (int k = 0; k < 400; k++) begin
            logic [31:0] ia, ib, pa;
            bit wa, wb, va, vb, rd, fl;
            int s = $urandom_range(0, 7);
            pa = 32'h1000 + 32'(k * 16);
            case (s)
                0: begin ia = eb(3'b000, 5'd1, 5'd2, 8); wa = 1; end
                1: begin ia = eb(3'b110, 5'd3, 5'd4, 6); wa = 1; end
                2: begin ia = ecb(1, 3'd3, 4); wa = 0; end
                3: begin ia = ecb(0, 3'd4, 6); wa = 0; end
                4: begin ia = eb(3'b000, 5'd1, 5'd2, 16); wa = 1; end
                5: begin ia = CADDI; wa = 0; end
                default: begin ia = ADDI; wa = 1; end
            endcase
            case ($urandom_range(0, 4))
                0: begin ib = LW; wb = 1; end
                1: begin ib = CADDI; wb = 0; end
                2: begin ib = CLW; wb = 0; end
                default: begin ib = ADDI; wb = 1; end
            endcase
            va = $urandom_range(0, 5) != 0;
            vb = $urandom_range(0, 3) != 0;
            rd = $urandom_range(0, 4) != 0;
            fl = $urandom_range(0, 19) == 0;
            cyc("R2", va, ia, pa, wa, vb, ib, pa + (wa ? 32'd4 : 32'd2), wb, rd, fl);
        end
        idle("R2");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule